// File: doc/BRIEF.md
# Composite Sync Separator and Equalization Corrector

This block takes a composite sync stream whose active level is high and splits it into a horizontal sync output and an extracted vertical sync output. Each active pulse is sorted by its width in clock cycles into one of three kinds. A pulse narrower than the equalization limit is an equalization pulse. A pulse at least as wide as the vertical limit is a broad (vertical) pulse. Any other pulse is a line pulse. The line period is measured between the ends of consecutive line pulses. The width of the most recent line pulse is also kept.

The extracted vertical pulse starts as soon as an active interval reaches the vertical limit. It ends after the first non-broad pulse that follows. Equalization pulses seen before the vertical interval raise a sticky pre flag. Those seen during or after it raise a sticky post flag. When inhibit is selected, the horizontal output is regenerated at the measured line rate, so the half-line pulses never reach it. The vertical output can be stretched by a programmable number of line periods. Two selectable conditions decide when the stretch applies.

Top module: `csync_separator`

## Requirements
- R1: After reset, `hsync_out`, `vsync_out`, `pre_eq_seen` and `post_eq_seen` are all 0.
- R2: With `inhibit_eq` = 0, `hsync_out` copies `csync_in` three clock cycles later, equalization pulses included.
- R3: `vsync_out` rises `vs_limit` cycles after a broad pulse starts. Without a stretch, it stays high until one cycle after the end of the first non-broad pulse that follows. Its high time is therefore nb·H + W + 1 − `vs_limit`, where nb broad pulses sit at half-line spacing H and the ending pulse is W cycles wide.
- R4: An equalization pulse that ends outside the vertical interval, with no vertical interval since the last line pulse, sets `pre_eq_seen`.
- R5: An equalization pulse that ends during the vertical interval, or after it and before the next line pulse, sets `post_eq_seen`. A vertical interval that is followed directly by line pulses leaves it at 0.
- R6: Both flags stay set until a cycle with `flags_clear` = 1, which returns them to 0.
- R7: With `inhibit_eq` = 1, `hsync_out` rises exactly once per measured line period, through the equalization and vertical intervals. Rising edges of `csync_in` are accepted for resynchronization only in the last quarter of the period.
- R8: With `ext_mode` = 0 and `ext_lines` = n > 0, a vertical interval ended by an equalization pulse is followed directly by n·L more cycles of `vsync_out` high, where L is the measured line period.
- R9: With `ext_mode` = 1, the stretch of R8 applies only if pre-equalization pulses were also seen before that vertical interval.
- R10: With `ext_lines` = 0, or when the vertical interval ends on a line pulse, no stretch is added.
- R11: The line period L is the spacing, in cycles, between the ends of two consecutive line pulses, and it follows a change of line rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one measurement tick |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csync_in | input | 1 | Composite sync, active high |
| eq_limit | input | CNT_W | Pulses narrower than this are equalization pulses |
| vs_limit | input | CNT_W | Active intervals reaching this are vertical |
| inhibit_eq | input | 1 | 1: regenerate the horizontal output at the line rate |
| ext_mode | input | 1 | 0: stretch on post-equalization; 1: stretch only if pre and post seen |
| ext_lines | input | EXT_W | Stretch length in line periods |
| flags_clear | input | 1 | Clears both sticky flags |
| hsync_out | output | 1 | Horizontal sync output |
| vsync_out | output | 1 | Extracted, optionally stretched vertical sync |
| pre_eq_seen | output | 1 | Sticky pre-equalization flag |
| post_eq_seen | output | 1 | Sticky post-equalization flag |

## Verification
The assertions assume that `eq_limit` is below `vs_limit`, that both limits and the control bits are static while a frame is in progress, and that the line period stays well below the counter range. The stimulus therefore changes the limits and modes only between frames. It builds every frame from whole line slots and whole half-line slots, which have fixed widths. It always sends at least two plain lines before a vertical interval, so the line period is valid before any stretch is counted. The extension length and both mode bits are swept over every combination, with and without pre-equalization.

// File: rtl/csep_pkg.sv
package csep_pkg;
  typedef enum logic [1:0] {
    PK_NONE  = 2'd0,
    PK_EQ    = 2'd1,
    PK_LINE  = 2'd2,
    PK_BROAD = 2'd3
  } pulse_kind_t;
endpackage

// File: rtl/csep_pulse_meas.sv
module csep_pulse_meas
  import csep_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int LINE_DEF = 64,
  parameter int HSW_DEF  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csync_i,
  input  logic [CNT_W-1:0] eq_lim_i,
  input  logic [CNT_W-1:0] vs_lim_i,
  output logic             lvl_o,
  output logic             rise_o,
  output logic             vs_hit_o,
  output pulse_kind_t      kind_o,
  output logic [CNT_W-1:0] line_per_o,
  output logic [CNT_W-1:0] hs_width_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] LINE_RST = CNT_W'(LINE_DEF);
  localparam logic [CNT_W-1:0] HSW_RST  = CNT_W'(HSW_DEF);

  logic             s1_q, s2_q, s3_q;
  logic [CNT_W-1:0] wcnt_q, wcnt_d, w_inc;
  logic [CNT_W-1:0] pcnt_q, pcnt_d, p_inc;
  logic [CNT_W-1:0] linep_q, linep_d;
  logic [CNT_W-1:0] hsw_q, hsw_d;
  logic             prevn_q, prevn_d;
  logic             fall;
  pulse_kind_t      kind;

  always_comb begin
    rise_o   = s2_q & ~s3_q;
    fall     = ~s2_q & s3_q;
    w_inc    = (wcnt_q == CNT_MAX) ? wcnt_q : wcnt_q + 1'b1;
    wcnt_d   = s2_q ? w_inc : '0;
    vs_hit_o = s2_q && (wcnt_q != CNT_MAX) && (w_inc == vs_lim_i);
    kind = PK_NONE;
    if (fall) begin
      if (wcnt_q >= vs_lim_i)     kind = PK_BROAD;
      else if (wcnt_q < eq_lim_i) kind = PK_EQ;
      else                        kind = PK_LINE;
    end
    p_inc   = (pcnt_q == CNT_MAX) ? pcnt_q : pcnt_q + 1'b1;
    pcnt_d  = (kind == PK_LINE) ? '0 : p_inc;
    linep_d = linep_q;
    hsw_d   = hsw_q;
    prevn_d = prevn_q;
    if (kind == PK_LINE) begin
      hsw_d   = wcnt_q;
      prevn_d = 1'b1;
      if (prevn_q) linep_d = p_inc;
    end else if (kind != PK_NONE) begin
      prevn_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      s3_q    <= 1'b0;
      wcnt_q  <= '0;
      pcnt_q  <= '0;
      linep_q <= LINE_RST;
      hsw_q   <= HSW_RST;
      prevn_q <= 1'b0;
    end else begin
      s1_q    <= csync_i;
      s2_q    <= s1_q;
      s3_q    <= s2_q;
      wcnt_q  <= wcnt_d;
      pcnt_q  <= pcnt_d;
      linep_q <= linep_d;
      hsw_q   <= hsw_d;
      prevn_q <= prevn_d;
    end
  end

  assign lvl_o      = s2_q;
  assign kind_o     = kind;
  assign line_per_o = linep_q;
  assign hs_width_o = hsw_q;

  // R11: a new line period is only taken at the end of a line pulse
  a_r11_period_on_line: assert property (@(posedge clk) disable iff (!rst_n)
    (linep_q != $past(linep_q)) |-> ($past(kind) == PK_LINE));
endmodule

// File: rtl/csep_vert_track.sv
module csep_vert_track
  import csep_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int EXT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pulse_kind_t      kind_i,
  input  logic             vs_hit_i,
  input  logic [CNT_W-1:0] line_per_i,
  input  logic             ext_mode_i,
  input  logic [EXT_W-1:0] ext_len_i,
  input  logic             clr_i,
  output logic             vso_o,
  output logic             pre_o,
  output logic             post_o
);
  logic             vraw_q, vraw_d;
  logic             after_q, after_d;
  logic             fpre_q, fpre_d;
  logic             pre_q, pre_d, post_q, post_d;
  logic [EXT_W-1:0] left_q, left_d;
  logic [CNT_W-1:0] tcnt_q, tcnt_d;
  logic             is_eq, ends_v, pre_seen, post_seen, start_ext, ext_on;

  always_comb begin
    is_eq     = (kind_i == PK_EQ);
    ends_v    = vraw_q && (kind_i == PK_EQ || kind_i == PK_LINE);
    pre_seen  = is_eq && !vraw_q && !after_q;
    post_seen = is_eq && (vraw_q || after_q);
    ext_on    = (left_q != '0);

    vraw_d = vraw_q;
    if (vs_hit_i)    vraw_d = 1'b1;
    else if (ends_v) vraw_d = 1'b0;

    after_d = after_q;
    if (vs_hit_i)                 after_d = 1'b0;
    else if (ends_v)              after_d = is_eq;
    else if (kind_i == PK_LINE)   after_d = 1'b0;

    fpre_d = fpre_q;
    if (ends_v)        fpre_d = 1'b0;
    else if (pre_seen) fpre_d = 1'b1;

    pre_d  = pre_seen  | (pre_q  & ~clr_i);
    post_d = post_seen | (post_q & ~clr_i);

    start_ext = ends_v && is_eq && (ext_len_i != '0) && (!ext_mode_i || fpre_q);
    left_d = left_q;
    tcnt_d = tcnt_q;
    if (start_ext) begin
      left_d = ext_len_i;
      tcnt_d = '0;
    end else if (ext_on) begin
      if (tcnt_q >= line_per_i - 1'b1) begin
        tcnt_d = '0;
        left_d = left_q - 1'b1;
      end else begin
        tcnt_d = tcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vraw_q  <= 1'b0;
      after_q <= 1'b0;
      fpre_q  <= 1'b0;
      pre_q   <= 1'b0;
      post_q  <= 1'b0;
      left_q  <= '0;
      tcnt_q  <= '0;
    end else begin
      vraw_q  <= vraw_d;
      after_q <= after_d;
      fpre_q  <= fpre_d;
      pre_q   <= pre_d;
      post_q  <= post_d;
      left_q  <= left_d;
      tcnt_q  <= tcnt_d;
    end
  end

  assign vso_o  = vraw_q | ext_on;
  assign pre_o  = pre_q;
  assign post_o = post_q;

  // R3: the vertical interval opens only on a width match from the measurer
  a_r3_vraw_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vraw_q) |-> $past(vs_hit_i));
  a_r6_pre_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_q && !clr_i) |=> pre_q);
  a_r6_post_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (post_q && !clr_i) |=> post_q);
  a_r8_ext_follows_v: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_on) |-> $fell(vraw_q));
  a_r9_mode1_needs_pre: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ext_on) && $past(ext_mode_i)) |-> $past(fpre_q));
  a_r10_no_ext_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_on) |-> ($past(ext_len_i) != '0));
endmodule

// File: rtl/csep_hregen.sv
module csep_hregen #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_i,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] line_per_i,
  input  logic [CNT_W-1:0] hs_width_i,
  input  logic             inhibit_i,
  output logic             hso_o
);
  logic [CNT_W-1:0] gcnt_q, gcnt_d, win_lo;
  logic             in_win, wrap, regen_d, hso_d, hso_q;

  always_comb begin
    win_lo  = line_per_i - (line_per_i >> 2);
    in_win  = rise_i && (gcnt_q >= win_lo);
    wrap    = (gcnt_q >= line_per_i - 1'b1);
    gcnt_d  = (in_win || wrap) ? '0 : gcnt_q + 1'b1;
    regen_d = (gcnt_d < hs_width_i);
    hso_d   = inhibit_i ? regen_d : lvl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcnt_q <= '0;
      hso_q  <= 1'b0;
    end else begin
      gcnt_q <= gcnt_d;
      hso_q  <= hso_d;
    end
  end

  assign hso_o = hso_q;

  // R7: the phase counter never runs past one measured line period
  a_r7_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (gcnt_q >= line_per_i) |=> (gcnt_q == '0));
endmodule

// File: rtl/csync_separator.sv
module csync_separator
  import csep_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int EXT_W    = 4,
  parameter int LINE_DEF = 64,
  parameter int HSW_DEF  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csync_in,
  input  logic [CNT_W-1:0] eq_limit,
  input  logic [CNT_W-1:0] vs_limit,
  input  logic             inhibit_eq,
  input  logic             ext_mode,
  input  logic [EXT_W-1:0] ext_lines,
  input  logic             flags_clear,
  output logic             hsync_out,
  output logic             vsync_out,
  output logic             pre_eq_seen,
  output logic             post_eq_seen
);
  logic             rst_meta_q, rst_sync_q;
  logic             lvl, rise, vs_hit;
  pulse_kind_t      kind;
  logic [CNT_W-1:0] line_per, hs_width;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  csep_pulse_meas #(.CNT_W(CNT_W), .LINE_DEF(LINE_DEF), .HSW_DEF(HSW_DEF)) u_meas (
    .clk(clk), .rst_n(rst_sync_q), .csync_i(csync_in),
    .eq_lim_i(eq_limit), .vs_lim_i(vs_limit),
    .lvl_o(lvl), .rise_o(rise), .vs_hit_o(vs_hit), .kind_o(kind),
    .line_per_o(line_per), .hs_width_o(hs_width)
  );

  csep_vert_track #(.CNT_W(CNT_W), .EXT_W(EXT_W)) u_vert (
    .clk(clk), .rst_n(rst_sync_q), .kind_i(kind), .vs_hit_i(vs_hit),
    .line_per_i(line_per), .ext_mode_i(ext_mode), .ext_len_i(ext_lines),
    .clr_i(flags_clear), .vso_o(vsync_out), .pre_o(pre_eq_seen), .post_o(post_eq_seen)
  );

  csep_hregen #(.CNT_W(CNT_W)) u_hgen (
    .clk(clk), .rst_n(rst_sync_q), .lvl_i(lvl), .rise_i(rise),
    .line_per_i(line_per), .hs_width_i(hs_width), .inhibit_i(inhibit_eq),
    .hso_o(hsync_out)
  );

  // R1: outputs are quiet while the internal reset is held
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    (!rst_sync_q) |-> (!hsync_out && !vsync_out && !pre_eq_seen && !post_eq_seen));
endmodule

// File: tb/csync_separator_test.sv
module csync_separator_test;
  localparam int CNT_W = 10;
  localparam int EXT_W = 4;
  localparam int VT    = 16;
  localparam int EQL   = 4;
  localparam int HW    = 6;
  localparam int EQW   = 2;
  localparam int NB    = 6;
  localparam int NE    = 6;

  logic clk = 1'b0;
  logic rst_n, csync, inh, mode, clr;
  logic [EXT_W-1:0] ext;
  logic hso, vso, pre_f, post_f;

  int nchk = 0, nfail = 0, cyc = 0;
  int vso_cnt, mism, last_rise, min_sp, max_sp;
  logic h1 = 1'b0, h2 = 1'b0, h3 = 1'b0, hso_prev = 1'b0;

  always #10 clk = ~clk;

  csync_separator #(.CNT_W(CNT_W), .EXT_W(EXT_W)) uut (
    .clk(clk), .rst_n(rst_n), .csync_in(csync),
    .eq_limit(CNT_W'(EQL)), .vs_limit(CNT_W'(VT)),
    .inhibit_eq(inh), .ext_mode(mode), .ext_lines(ext), .flags_clear(clr),
    .hsync_out(hso), .vsync_out(vso), .pre_eq_seen(pre_f), .post_eq_seen(post_f)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic track_reset();
    mism = 0; last_rise = -1; min_sp = 1 << 20; max_sp = 0;
  endtask

  task automatic step(input logic v);
    @(negedge clk);
    cyc++;
    if (vso) vso_cnt++;
    if (hso !== h3) mism++;
    if (hso && !hso_prev) begin
      if (last_rise >= 0) begin
        if (cyc - last_rise < min_sp) min_sp = cyc - last_rise;
        if (cyc - last_rise > max_sp) max_sp = cyc - last_rise;
      end
      last_rise = cyc;
    end
    hso_prev = hso;
    h3 = h2; h2 = h1; h1 = v;
    csync = v;
  endtask

  task automatic lines(input int l, input int n);
    for (int k = 0; k < n; k++)
      for (int i = 0; i < l; i++) step(i < HW);
  endtask

  task automatic halves(input int h, input bit broad, input int n);
    for (int k = 0; k < n; k++)
      for (int i = 0; i < h; i++) step(broad ? (i < h - 4) : (i < EQW));
  endtask

  task automatic frame(input int l, input bit wpre, input bit wpost, input int nbef, input int naft);
    vso_cnt = 0;
    lines(l, nbef);
    if (wpre) halves(l / 2, 1'b0, NE);
    halves(l / 2, 1'b1, NB);
    if (wpost) halves(l / 2, 1'b0, NE);
    lines(l, naft);
  endtask

  task automatic clear_flags();
    clr = 1'b1;
    step(1'b0);
    clr = 1'b0;
  endtask

  function automatic int exp_vso(input int l, input bit wpre, input bit wpost,
                                 input bit m, input int n);
    int d;
    d = NB * (l / 2) + (wpost ? EQW : HW) + 1 - VT;
    if (wpost && n != 0 && (!m || wpre)) d += n * l;
    return d;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; csync = 1'b0; inh = 1'b0; mode = 1'b0; clr = 1'b0; ext = '0;
    track_reset();
    vso_cnt = 0;
    repeat (4) step(1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) step(1'b0);
    chk("R1 hsync_out", hso, 0);
    chk("R1 vsync_out", vso, 0);
    chk("R1 pre flag", pre_f, 0);
    chk("R1 post flag", post_f, 0);

    // Pass-through frame with both equalization groups, no stretch
    lines(64, 4);
    clear_flags();
    track_reset();
    frame(64, 1'b1, 1'b1, 3, 4);
    chk("R3 vsync width", vso_cnt, exp_vso(64, 1, 1, 0, 0));
    chk("R4 pre flag set", pre_f, 1);
    chk("R5 post flag set", post_f, 1);
    chk("R2 pass-through mismatches", mism, 0);
    chk("R2 half-line pulses visible", min_sp, 32);

    // R6: flags persist across plain lines, then clear
    lines(64, 5);
    chk("R6 pre sticky", pre_f, 1);
    chk("R6 post sticky", post_f, 1);
    clear_flags();
    step(1'b0);
    chk("R6 pre cleared", pre_f, 0);
    chk("R6 post cleared", post_f, 0);

    // R10/R5: vertical ended by a line pulse, stretch requested but not applied
    ext = 4'd3;
    frame(64, 1'b1, 1'b0, 3, 6);
    chk("R10 no stretch without post-eq", vso_cnt, exp_vso(64, 1, 0, 0, 3));
    chk("R5 post flag stays 0", post_f, 0);
    chk("R4 pre flag", pre_f, 1);

    // R7: regenerated horizontal output
    ext = '0;
    inh = 1'b1;
    lines(64, 3);
    track_reset();
    frame(64, 1'b1, 1'b1, 3, 4);
    chk("R7 min spacing", min_sp, 64);
    chk("R7 max spacing", max_sp, 64);
    chk("R3 vsync width under inhibit", vso_cnt, exp_vso(64, 1, 1, 0, 0));
    inh = 1'b0;
    lines(64, 2);

    // R11: changed line rate
    ext = 4'd2; mode = 1'b0;
    lines(48, 4);
    clear_flags();
    frame(48, 1'b1, 1'b1, 2, 5);
    chk("R11 stretch at 48-cycle lines", vso_cnt, exp_vso(48, 1, 1, 0, 2));
    lines(64, 4);

    // R8/R9/R10 sweep over mode, pre presence and every stretch length
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < 2; p++)
        for (int n = 0; n < 16; n++) begin
          mode = m[0];
          ext  = EXT_W'(n);
          clear_flags();
          frame(64, p[0], 1'b1, 2, n + 3);
          if (n == 0)
            chk("R10 zero length", vso_cnt, exp_vso(64, p[0], 1, m[0], n));
          else if (m == 0)
            chk("R8 post-only stretch", vso_cnt, exp_vso(64, p[0], 1, m[0], n));
          else
            chk("R9 pre-and-post stretch", vso_cnt, exp_vso(64, p[0], 1, m[0], n));
          chk("R4 pre flag in sweep", pre_f, p);
          chk("R5 post flag in sweep", post_f, 1);
        end

    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule